// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two 8+8-bit timer/counters. A single mode byte configures both of them. Each timer can count a divided-down clock tick or falling edges on its own external count pin. An external gate pin can hold a timer's counting off. Software sets the mode byte, the two run bits, the four count bytes and the two overflow flags through a small synchronous register port. An interrupt controller outside the block reads the flags as level outputs. When it services an interrupt it pulses an acknowledge line, and that pulse clears the matching flag.

Each timer has four modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself from the high byte, and a split mode. In split mode timer 0 becomes two independent 8-bit counters, and the second of them uses timer 1's run bit and overflow flag. While timer 0 is split, timer 1 is frozen. Every overflow of timer 1 also drives a one-cycle rate pulse to a serial port, and this pulse does not depend on timer 1's flag.

Top module: `timer_pair`

## Requirements
- R1: After reset the mode byte, run bits, all four count bytes and both flags read 0, and `irq_flag` and `baud_tick` are low.
- R2: In tick mode (mode bit 2 = 0), a running timer advances once every DIV clocks. With its run bit at 0 its count holds. Run bits are at address 1, with bit 0 for timer 0 and bit 1 for timer 1.
- R3: In counter mode (mode bit 2 = 1), the count pin is sampled on every tick. The count advances once for each tick that sees the pin at 0 when the previous tick saw 1. Falling edges that occur while the run bit is 0 are not counted.
- R4: When the gate bit (mode bit 3 of the timer's nibble) is 1, the timer counts only while its `gate_pin` is high.
- R5: Mode 0 (mode bits 1:0 = 00) counts a 13-bit value made of the high byte and low-byte bits 4:0. Low-byte bits 7:5 keep their value. Rolling over from all ones to zero sets the timer's flag.
- R6: Mode 1 (mode bits 1:0 = 01) counts the high:low bytes as one 16-bit value. Rolling over from 0xFFFF to 0 sets the flag.
- R7: Mode 2 (mode bits 1:0 = 10) counts the low byte only. At 0xFF the next count loads the low byte from the high byte and sets the flag.
- R8: When timer 0 uses mode 3 (mode bits 1:0 = 11), its low byte is an 8-bit counter under timer 0's run bit, gate and flag. Its high byte is an 8-bit tick counter under timer 1's run bit that sets timer 1's flag. Timer 1's count bytes hold.
- R9: An `irq_ack` pulse clears the matching flag. The flags read at address 6, with bit 0 for timer 0 and bit 1 for timer 1. A write to address 6 sets or clears them.
- R10: Each rollover of timer 1 in modes 0 to 2 produces a one-cycle `baud_tick` pulse, whether timer 1's flag is already set or not.
- R11: The mode byte is at address 0, with timer 0 in bits 3:0 and timer 1 in bits 7:4. The count bytes are at addresses 2 (timer 0 low), 3 (timer 0 high), 4 (timer 1 low) and 5 (timer 1 high). A count-byte write overrides a count that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cnt_pin | input | 2 | External count pins, one per timer |
| gate_pin | input | 2 | External gate pins, one per timer |
| irq_ack | input | 2 | Flag clear pulses from the interrupt controller |
| irq_flag | output | 2 | Overflow flags |
| baud_tick | output | 1 | One-cycle pulse on each timer 1 rollover |

## Verification
The bench builds the block with DIV = 4 in place of the default 12. A window of k·4 clocks then holds exactly k ticks whatever the prescaler phase, so each run-bit window has an exact count. Every rollover is reached in a few ticks by preloading the count bytes close to all ones, including the 13-bit wrap, the reload wrap and both halves of the split mode. The bench also tracks the prescaler phase from reset, which lets it place a count-byte write on the very cycle of a count.

// File: rtl/timer_pair_pkg.sv
// Shared types and register addresses for the dual timer/counter.
package timer_pair_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    // Counting mode held in bits 1:0 of each timer nibble.
    typedef enum logic [1:0] {
        TM_13B    = 2'b00,
        TM_16B    = 2'b01,
        TM_RELOAD = 2'b10,
        TM_SPLIT  = 2'b11
    } tmode_e;

    // One timer nibble: gate enable, external-count select, mode.
    typedef struct packed {
        logic   gate;
        logic   ext;
        tmode_e mode;
    } tcfg_t;

    localparam logic [ADDR_W-1:0] RA_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] RA_RUN  = 3'd1;
    localparam logic [ADDR_W-1:0] RA_LO0  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_HI0  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_LO1  = 3'd4;
    localparam logic [ADDR_W-1:0] RA_HI1  = 3'd5;
    localparam logic [ADDR_W-1:0] RA_FLAG = 3'd6;
endpackage

// File: rtl/timer_pair_prescale.sv
// Free-running clock divider. It gives a one-cycle tick every DIV clocks.
// Assumes DIV >= 2. The phase restarts at reset.
module timer_pair_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/timer_pair_edge.sv
// Falling-edge finder for one external count pin. It samples the pin only
// on sample-enable cycles and reports 1-then-0 across two samples.
// Assumes the pin is already synchronous to clk.
module timer_pair_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic pin,
    output logic fall
);
    logic prev_q;

    assign fall = smp_en & prev_q & ~pin;

    // Remember the pin level seen at the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (smp_en) prev_q <= pin;
    end
endmodule

// File: rtl/timer_pair_core.sv
// Count bytes of one timer and their next-state logic in the four modes.
// inc advances the main counter. inc_hi advances the high byte alone and
// only has an effect in split mode. Byte writes override counting.
// The overflow outputs are combinational and valid in the cycle of the count.
module timer_pair_core
    import timer_pair_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int LOW_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmode_e        mode,
    input  logic          inc,
    input  logic          inc_hi,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi,
    output logic          ovf,
    output logic          ovf_hi
);
    localparam int NAR_W = BW + LOW_W;
    localparam int WID_W = 2 * BW;

    logic [BW-1:0]    lo_q, hi_q, lo_n, hi_n;
    logic [NAR_W-1:0] nar, nar_inc;
    logic [WID_W-1:0] wid, wid_inc;

    assign nar     = {hi_q, lo_q[LOW_W-1:0]};
    assign nar_inc = nar + 1'b1;
    assign wid     = {hi_q, lo_q};
    assign wid_inc = wid + 1'b1;

    // Next count value and overflow for the selected mode.
    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf    = 1'b0;
        ovf_hi = 1'b0;
        if (inc) begin
            unique case (mode)
                TM_13B: begin
                    ovf               = &nar;
                    hi_n              = nar_inc[NAR_W-1:LOW_W];
                    lo_n[LOW_W-1:0]   = nar_inc[LOW_W-1:0];
                end
                TM_16B: begin
                    ovf          = &wid;
                    {hi_n, lo_n} = wid_inc;
                end
                TM_RELOAD: begin
                    ovf  = &lo_q;
                    lo_n = (&lo_q) ? hi_q : lo_q + 1'b1;
                end
                TM_SPLIT: begin
                    ovf  = &lo_q;
                    lo_n = lo_q + 1'b1;
                end
                default: ;
            endcase
        end
        if (inc_hi && mode == TM_SPLIT) begin
            ovf_hi = &hi_q;
            hi_n   = hi_q + 1'b1;
        end
        if (wr_lo) lo_n = wdata;
        if (wr_hi) hi_n = wdata;
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign lo = lo_q;
    assign hi = hi_q;

    // R2: with no count and no write, both bytes hold
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !inc_hi && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    // R5: in the 13-bit mode the upper low-byte bits keep their value
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_13B && !wr_lo) |=> (lo_q[BW-1:LOW_W] == $past(lo_q[BW-1:LOW_W])));

    // R7: a wrap in reload mode copies the old high byte into the low byte
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_RELOAD && inc && (&lo_q) && !wr_lo) |=> (lo_q == $past(hi_q)));

    // R6: a 16-bit wrap leaves zero in both bytes
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_16B && inc && (&wid) && !wr_lo && !wr_hi) |=> (lo_q == '0 && hi_q == '0));
endmodule

// File: rtl/timer_pair.sv
// Dual four-mode timer/counter with a small register port.
// Each timer counts prescaler ticks or falling edges on its count pin. It
// runs under its run bit and, optionally, its gate pin. Overflows set
// level flags, and acknowledge pulses clear them. Timer 1's rollovers also
// give a rate pulse. Assumes DIV >= 2 and count/gate pins synchronous to clk.
module timer_pair
    import timer_pair_pkg::*;
#(
    parameter int DIV   = 12,
    parameter int LOW_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        irq_ack,
    output logic [1:0]        irq_flag,
    output logic              baud_tick
);
    localparam int NT = 2;
    localparam int NW = 4;

    logic [BYTE_W-1:0] mode_q;
    logic [NT-1:0]     run_q, flag_q, flag_set, ev, fall;
    logic              tick, baud_q;
    tmode_e            t0_mode, t1_mode;
    logic              split;
    logic [BYTE_W-1:0] lo0, hi0, lo1, hi1;
    logic              ovf0, ovfh0, ovf1, ovfh1;
    logic              wr_mode, wr_run, wr_flag;

    assign wr_mode = bus_wr && bus_addr == RA_MODE;
    assign wr_run  = bus_wr && bus_addr == RA_RUN;
    assign wr_flag = bus_wr && bus_addr == RA_FLAG;

    assign t0_mode = tmode_e'(mode_q[1:0]);
    assign t1_mode = tmode_e'(mode_q[NW+1:NW]);
    assign split   = (t0_mode == TM_SPLIT);

    timer_pair_prescale #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Per-timer enable, edge detect and count-event select.
    for (genvar i = 0; i < NT; i++) begin : g_src
        tcfg_t cfg;
        logic  en;
        assign cfg = tcfg_t'(mode_q[NW*i +: NW]);
        assign en  = run_q[i] & (~cfg.gate | gate_pin[i]);

        timer_pair_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_en (tick),
            .pin    (cnt_pin[i]),
            .fall   (fall[i])
        );

        assign ev[i] = en & (cfg.ext ? fall[i] : tick);
    end

    timer_pair_core #(.BW(BYTE_W), .LOW_W(LOW_W)) u_t0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (t0_mode),
        .inc    (ev[0]),
        .inc_hi (split & run_q[1] & tick),
        .wr_lo  (bus_wr && bus_addr == RA_LO0),
        .wr_hi  (bus_wr && bus_addr == RA_HI0),
        .wdata  (bus_wdata),
        .lo     (lo0),
        .hi     (hi0),
        .ovf    (ovf0),
        .ovf_hi (ovfh0)
    );

    timer_pair_core #(.BW(BYTE_W), .LOW_W(LOW_W)) u_t1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (t1_mode),
        .inc    (ev[1] & ~split & (t1_mode != TM_SPLIT)),
        .inc_hi (1'b0),
        .wr_lo  (bus_wr && bus_addr == RA_LO1),
        .wr_hi  (bus_wr && bus_addr == RA_HI1),
        .wdata  (bus_wdata),
        .lo     (lo1),
        .hi     (hi1),
        .ovf    (ovf1),
        .ovf_hi (ovfh1)
    );

    assign flag_set[0] = ovf0;
    assign flag_set[1] = split ? ovfh0 : (ovf1 | ovfh1);

    // Mode byte and run bits, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata;
            if (wr_run)  run_q  <= bus_wdata[NT-1:0];
        end
    end

    // Flags: a software write wins, then an overflow set, then an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (wr_flag)          flag_q[i] <= bus_wdata[i];
                else if (flag_set[i]) flag_q[i] <= 1'b1;
                else if (irq_ack[i])  flag_q[i] <= 1'b0;
            end
        end
    end

    // Registered rate pulse from timer 1 rollovers.
    always_ff @(posedge clk) begin
        if (!rst_n) baud_q <= 1'b0;
        else        baud_q <= ovf1;
    end

    // Register read mux.
    always_comb begin
        unique case (bus_addr)
            RA_MODE: bus_rdata = mode_q;
            RA_RUN:  bus_rdata = {{(BYTE_W-NT){1'b0}}, run_q};
            RA_LO0:  bus_rdata = lo0;
            RA_HI0:  bus_rdata = hi0;
            RA_LO1:  bus_rdata = lo1;
            RA_HI1:  bus_rdata = hi1;
            RA_FLAG: bus_rdata = {{(BYTE_W-NT){1'b0}}, flag_q};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_flag  = flag_q;
    assign baud_tick = baud_q;

    // R9: an acknowledge with no competing set or write clears the flag
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[0] && !flag_set[0] && !wr_flag) |=> !irq_flag[0]);

    // R8: timer 1 bytes freeze while timer 0 is split
    a_r8_t1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !(bus_wr && (bus_addr == RA_LO1 || bus_addr == RA_HI1)))
        |=> ($stable(lo1) && $stable(hi1)));

    // R10: the rate pulse lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    // R3: in counter mode, with no pin fall and no write, timer 0 holds
    a_r3_no_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2] && !split && !fall[0] && !bus_wr) |=> ($stable(lo0) && $stable(hi0)));
endmodule

// File: tb/sim_timer_pair.sv
module sim_timer_pair;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] irq_flag;
    logic       baud_tick;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    int baud_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    timer_pair #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .irq_ack(irq_ack), .irq_flag(irq_flag),
        .baud_tick(baud_tick)
    );

    always @(posedge clk) if (rst_n) edges <= edges + 1;
    always @(negedge clk) if (baud_tick) baud_cnt <= baud_cnt + 1;

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Run bits on for exactly k*DIV clock edges, hence exactly k ticks.
    task automatic run_ticks(input logic [7:0] on, input int k);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = on;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (k * DIV - 1) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic preload0(input logic [7:0] md, input logic [7:0] l, input logic [7:0] h);
        wr(3'd0, md); wr(3'd2, l); wr(3'd3, h); wr(3'd6, 8'h00);
    endtask

    task automatic t_reset;
        int v;
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], v);
            chk("R1 register after reset", v, 0);
        end
        chk("R1 irq_flag after reset", irq_flag, 0);
        chk("R1 baud_tick after reset", baud_tick, 0);
    endtask

    task automatic t_tick_count;
        int v;
        preload0(8'h01, 8'h00, 8'h00);
        run_ticks(8'h01, 10);
        rd(3'd2, v); chk("R2 ten ticks", v, 8'h0A);
        repeat (5 * DIV) @(negedge clk);
        rd(3'd2, v); chk("R2 hold while stopped", v, 8'h0A);
    endtask

    task automatic t_mode1_wrap;
        int v;
        preload0(8'h01, 8'hFE, 8'hFF);
        run_ticks(8'h01, 3);
        rd(3'd2, v); chk("R6 low after wrap", v, 8'h01);
        rd(3'd3, v); chk("R6 high after wrap", v, 8'h00);
        rd(3'd6, v); chk("R6 flag set", v, 8'h01);
        chk("R6 irq_flag port", irq_flag, 2'b01);
    endtask

    task automatic t_ack;
        int v;
        @(negedge clk); irq_ack = 2'b01;
        @(negedge clk); irq_ack = 2'b00;
        rd(3'd6, v); chk("R9 flag cleared by ack", v, 8'h00);
        wr(3'd6, 8'h02);
        chk("R9 flag set by write", irq_flag, 2'b10);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_mode0;
        int v;
        preload0(8'h00, 8'hFE, 8'hFF);
        run_ticks(8'h01, 3);
        rd(3'd2, v); chk("R5 low keeps bits 7:5", v, 8'hE1);
        rd(3'd3, v); chk("R5 high after wrap", v, 8'h00);
        rd(3'd6, v); chk("R5 flag set", v, 8'h01);
    endtask

    task automatic t_mode2;
        int v;
        preload0(8'h02, 8'hFE, 8'hF0);
        run_ticks(8'h01, 5);
        rd(3'd2, v); chk("R7 low after reload", v, 8'hF3);
        rd(3'd3, v); chk("R7 high unchanged", v, 8'hF0);
        rd(3'd6, v); chk("R7 flag set", v, 8'h01);
    endtask

    task automatic t_counter;
        int v;
        preload0(8'h05, 8'h00, 8'h00);
        cnt_pin[0] = 1'b1;
        repeat (3 * DIV) @(negedge clk);
        wr(3'd1, 8'h01);
        for (int n = 0; n < 4; n++) begin
            cnt_pin[0] = 1'b0; repeat (3 * DIV) @(negedge clk);
            cnt_pin[0] = 1'b1; repeat (3 * DIV) @(negedge clk);
        end
        wr(3'd1, 8'h00);
        rd(3'd2, v); chk("R3 four falling edges", v, 8'h04);
        for (int n = 0; n < 2; n++) begin
            cnt_pin[0] = 1'b0; repeat (3 * DIV) @(negedge clk);
            cnt_pin[0] = 1'b1; repeat (3 * DIV) @(negedge clk);
        end
        rd(3'd2, v); chk("R3 edges ignored when stopped", v, 8'h04);
    endtask

    task automatic t_gate;
        int v;
        preload0(8'h09, 8'h00, 8'h00);
        gate_pin[0] = 1'b0;
        run_ticks(8'h01, 8);
        rd(3'd2, v); chk("R4 gate low blocks count", v, 8'h00);
        gate_pin[0] = 1'b1;
        run_ticks(8'h01, 8);
        rd(3'd2, v); chk("R4 gate high allows count", v, 8'h08);
        gate_pin[0] = 1'b0;
    endtask

    task automatic t_split;
        int v, b0;
        preload0(8'h13, 8'hFE, 8'hFD);
        wr(3'd4, 8'h55); wr(3'd5, 8'h66);
        b0 = baud_cnt;
        run_ticks(8'h03, 3);
        rd(3'd2, v); chk("R8 split low byte", v, 8'h01);
        rd(3'd3, v); chk("R8 split high byte", v, 8'h00);
        rd(3'd6, v); chk("R8 both flags set", v, 8'h03);
        rd(3'd4, v); chk("R8 timer1 low frozen", v, 8'h55);
        rd(3'd5, v); chk("R8 timer1 high frozen", v, 8'h66);
        chk("R8 no rate pulse while split", baud_cnt - b0, 0);
    endtask

    task automatic t_baud;
        int v, b0;
        wr(3'd0, 8'h20); wr(3'd4, 8'hFC); wr(3'd5, 8'hFC); wr(3'd6, 8'h02);
        b0 = baud_cnt;
        run_ticks(8'h02, 8);
        @(negedge clk);
        chk("R10 two rate pulses with flag already set", baud_cnt - b0, 2);
        rd(3'd4, v); chk("R10 timer1 reloaded", v, 8'hFC);
        rd(3'd6, v); chk("R10 flags", v, 8'h02);
    endtask

    task automatic t_write_wins;
        int v;
        preload0(8'h01, 8'h10, 8'h00);
        rd(3'd0, v); chk("R11 mode byte readback", v, 8'h01);
        wr(3'd1, 8'h01);
        while (((edges + 1) % DIV) != 0) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h40;
        @(negedge clk);
        bus_wr = 1'b0;
        wr(3'd1, 8'h00);
        rd(3'd2, v); chk("R11 write beats same-cycle count", v, 8'h40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick_count();
        t_mode1_wrap();
        t_ack();
        t_mode0();
        t_mode2();
        t_counter();
        t_gate();
        t_split();
        t_baud();
        t_write_wins();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule